// File: doc/BRIEF.md
# Serial Channel DMA Handshake Logic

This block sits beside one channel of a serial controller that owns a receive FIFO and a transmit FIFO. It turns FIFO status levels and configuration inputs into active-low DMA request pins. It synchronises the active-low acknowledge pins and turns each acknowledge into a single-cycle FIFO read or FIFO load strobe. Through an output-enable and a separate sample input, it also drives and observes a shared open-drain last-transfer (DONE) line. The FIFOs, the serial engines and the host registers sit outside the block.

A two-bit mode input selects the role of the pins:

- **Half-duplex DMA.** One request and acknowledge pair serves whichever direction is enabled.
- **Full-duplex DMA.** The shared pair carries receive traffic only, and a second pair carries transmit traffic.
- **Non-DMA.** The request pins become software-driven outputs. The acknowledge pins remain readable as general-purpose inputs.

Top module: `sio_dma_handshake`

## Requirements
- R1: Mode encoding is 2'b00 non-DMA, 2'b01 half-duplex DMA, 2'b10 full-duplex DMA, and 2'b11 behaves as non-DMA. All request and acknowledge pins are active-low (0 = asserted).
- R2: In half-duplex mode, `req_n_o` is 0 exactly when (`rx_en_i` and `rx_avail_i`) or (`tx_en_i` and not `tx_full_i`).
- R3: In full-duplex mode, `req_n_o` is 0 exactly when `rx_en_i` and `rx_avail_i`, and `txreq_n_o` is 0 exactly when `tx_en_i` and not `tx_full_i`.
- R4: In non-DMA mode, `req_n_o` equals the inverse of `sw_req_i`. In every mode other than full-duplex, `txreq_n_o` equals the inverse of `sw_rts_i` when `sw_txsel_i` is 1, and the inverse of `sw_txgpo_i` when it is 0.
- R5: In half-duplex mode, a falling edge on `ack_n_i` gives one `rx_rd_o` pulse when the receiver is enabled. Otherwise it gives one `tx_wr_o` pulse when the transmitter is enabled. It never gives both pulses.
- R6: In full-duplex mode, an `ack_n_i` falling edge gives `rx_rd_o` and a `txack_n_i` falling edge gives `tx_wr_o`, independently and possibly in the same cycle. In half-duplex mode, `txack_n_i` has no effect.
- R7: Each acknowledge falling edge gives exactly one strobe cycle, however long the pin stays low. The strobe is high during the second clock cycle after the first rising edge that samples the pin low. No strobe is produced in non-DMA modes, `rx_rd_o` needs `rx_avail_i`, and `tx_wr_o` needs `tx_full_i` low.
- R8: `ack_lvl_o` and `txack_lvl_o` follow their pins with a delay of two rising edges, in every mode.
- R9: `done_oe_o` is 1 only in a cycle where `rx_rd_o` is 1 with `rx_last_i` set, or where `tx_wr_o` is 1 with `tx_tc_i` set.
- R10: `tx_last_o` pulses together with `tx_wr_o` when the synchronised `done_n_i` is low, and stays 0 otherwise.
- R11: During and after reset, with idle pins, the strobes, `done_oe_o` and `tx_last_o` are 0, and both acknowledge level outputs are 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mode_i | input | 2 | DMA mode select |
| rx_en_i | input | 1 | Receiver enabled |
| tx_en_i | input | 1 | Transmitter enabled |
| rx_avail_i | input | 1 | Receive FIFO holds at least one character |
| tx_full_i | input | 1 | Transmit FIFO full |
| sw_req_i | input | 1 | Software level for shared request pin in non-DMA |
| sw_txsel_i | input | 1 | Transmit request pin role: 1 request-to-send, 0 general output |
| sw_txgpo_i | input | 1 | Software general-output level for transmit request pin |
| sw_rts_i | input | 1 | Software request-to-send level |
| rx_last_i | input | 1 | Next receive read is the final DMA transfer |
| tx_tc_i | input | 1 | Transmit character count at terminal count |
| ack_n_i | input | 1 | Shared acknowledge pin, active-low |
| txack_n_i | input | 1 | Transmit acknowledge pin, active-low |
| done_n_i | input | 1 | Sampled level of the DONE line |
| req_n_o | output | 1 | Shared request pin, active-low |
| txreq_n_o | output | 1 | Transmit request pin, active-low |
| ack_lvl_o | output | 1 | Synchronised shared acknowledge level |
| txack_lvl_o | output | 1 | Synchronised transmit acknowledge level |
| rx_rd_o | output | 1 | Receive FIFO read strobe |
| tx_wr_o | output | 1 | Transmit FIFO load strobe |
| tx_last_o | output | 1 | Final transmit load marked by DONE input |
| done_oe_o | output | 1 | Pull the DONE line low |

## Verification
The bench holds each acknowledge low for several cycles and counts the strobes. A level-sensitive design would return a count above one, and a design with a wrong synchroniser depth would put the strobe on the wrong cycle index. Half-duplex with both directions enabled checks receive priority: a design without it would issue both strobes. The bench drives the transmit acknowledge in half-duplex mode and the shared acknowledge in non-DMA mode, and a design that failed to ignore them would show spurious strobes. Checks of DONE against the final-transfer flags catch an output-enable that stays high too long or fires on ordinary transfers.

// File: rtl/sio_dma_handshake.sv
module sio_dma_handshake (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] mode_i,
  input  logic       rx_en_i,
  input  logic       tx_en_i,
  input  logic       rx_avail_i,
  input  logic       tx_full_i,
  input  logic       sw_req_i,
  input  logic       sw_txsel_i,
  input  logic       sw_txgpo_i,
  input  logic       sw_rts_i,
  input  logic       rx_last_i,
  input  logic       tx_tc_i,
  input  logic       ack_n_i,
  input  logic       txack_n_i,
  input  logic       done_n_i,
  output logic       req_n_o,
  output logic       txreq_n_o,
  output logic       ack_lvl_o,
  output logic       txack_lvl_o,
  output logic       rx_rd_o,
  output logic       tx_wr_o,
  output logic       tx_last_o,
  output logic       done_oe_o
);

  localparam logic [1:0] MODE_HALF = 2'b01;
  localparam logic [1:0] MODE_FULL = 2'b10;

  logic [2:0] ack_q;
  logic [2:0] txack_q;
  logic [1:0] done_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ack_q   <= 3'b111;
      txack_q <= 3'b111;
      done_q  <= 2'b11;
    end else begin
      ack_q   <= {ack_q[1:0], ack_n_i};
      txack_q <= {txack_q[1:0], txack_n_i};
      done_q  <= {done_q[0], done_n_i};
    end
  end

  logic half, full, dma;
  logic rx_want, tx_want;
  logic ack_fall, txack_fall;

  assign half = (mode_i == MODE_HALF);
  assign full = (mode_i == MODE_FULL);
  assign dma  = half | full;

  assign rx_want = rx_en_i & rx_avail_i;
  assign tx_want = tx_en_i & ~tx_full_i;

  assign ack_fall   = ack_q[2] & ~ack_q[1];
  assign txack_fall = txack_q[2] & ~txack_q[1];

  assign req_n_o   = half ? ~(rx_want | tx_want) :
                     full ? ~rx_want : ~sw_req_i;
  assign txreq_n_o = full ? ~tx_want :
                     ~(sw_txsel_i ? sw_rts_i : sw_txgpo_i);

  assign ack_lvl_o   = ack_q[1];
  assign txack_lvl_o = txack_q[1];

  assign rx_rd_o = dma & ack_fall & rx_en_i & rx_avail_i;
  assign tx_wr_o = ((half & ack_fall & ~rx_en_i) | (full & txack_fall))
                   & tx_en_i & ~tx_full_i;

  assign done_oe_o = (rx_rd_o & rx_last_i) | (tx_wr_o & tx_tc_i);
  assign tx_last_o = tx_wr_o & ~done_q[1];

endmodule

module sio_dma_handshake_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [1:0] mode_i,
  input logic       ack_n_i,
  input logic       txack_n_i,
  input logic       tx_full_i,
  input logic       rx_last_i,
  input logic       tx_tc_i,
  input logic       txreq_n_o,
  input logic       rx_rd_o,
  input logic       tx_wr_o,
  input logic       tx_last_o,
  input logic       done_oe_o
);
  AST_HALF_ONE_DIR: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_i == 2'b01) |-> !(rx_rd_o && tx_wr_o)); // R5
  AST_RD_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    rx_rd_o |=> !rx_rd_o); // R7
  AST_WR_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    tx_wr_o |=> !tx_wr_o); // R7
  AST_RD_FROM_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    rx_rd_o |-> !$past(ack_n_i, 2)); // R7
  AST_NODMA_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_i == 2'b00 || mode_i == 2'b11) |-> !(rx_rd_o || tx_wr_o)); // R7
  AST_WR_NOT_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    tx_wr_o |-> !tx_full_i); // R7
  AST_FULL_TXREQ: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_i == 2'b10 && tx_full_i) |-> txreq_n_o); // R3
  AST_DONE_ON_XFER: assert property (@(posedge clk) disable iff (!rst_n)
    done_oe_o |-> ((rx_rd_o && rx_last_i) || (tx_wr_o && tx_tc_i))); // R9
  AST_LAST_WITH_WR: assert property (@(posedge clk) disable iff (!rst_n)
    tx_last_o |-> tx_wr_o); // R10
  AST_WR_FULL_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_wr_o && mode_i == 2'b10) |-> !$past(txack_n_i, 2)); // R6
endmodule

bind sio_dma_handshake sio_dma_handshake_chk u_chk (
  .clk(clk), .rst_n(rst_n), .mode_i(mode_i), .ack_n_i(ack_n_i),
  .txack_n_i(txack_n_i), .tx_full_i(tx_full_i), .rx_last_i(rx_last_i),
  .tx_tc_i(tx_tc_i), .txreq_n_o(txreq_n_o), .rx_rd_o(rx_rd_o),
  .tx_wr_o(tx_wr_o), .tx_last_o(tx_last_o), .done_oe_o(done_oe_o));

// File: tb/sio_dma_handshake_tb.sv
module sio_dma_handshake_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [1:0] mode_i = 2'b00;
  logic rx_en_i = 0, tx_en_i = 0, rx_avail_i = 0, tx_full_i = 0;
  logic sw_req_i = 0, sw_txsel_i = 0, sw_txgpo_i = 0, sw_rts_i = 0;
  logic rx_last_i = 0, tx_tc_i = 0;
  logic ack_n_i = 1, txack_n_i = 1, done_n_i = 1;
  logic req_n_o, txreq_n_o, ack_lvl_o, txack_lvl_o;
  logic rx_rd_o, tx_wr_o, tx_last_o, done_oe_o;

  int total = 0;
  int bad = 0;

  always #5 clk = ~clk;

  sio_dma_handshake u_dut (
    .clk(clk), .rst_n(rst_n), .mode_i(mode_i),
    .rx_en_i(rx_en_i), .tx_en_i(tx_en_i), .rx_avail_i(rx_avail_i), .tx_full_i(tx_full_i),
    .sw_req_i(sw_req_i), .sw_txsel_i(sw_txsel_i), .sw_txgpo_i(sw_txgpo_i), .sw_rts_i(sw_rts_i),
    .rx_last_i(rx_last_i), .tx_tc_i(tx_tc_i),
    .ack_n_i(ack_n_i), .txack_n_i(txack_n_i), .done_n_i(done_n_i),
    .req_n_o(req_n_o), .txreq_n_o(txreq_n_o), .ack_lvl_o(ack_lvl_o), .txack_lvl_o(txack_lvl_o),
    .rx_rd_o(rx_rd_o), .tx_wr_o(tx_wr_o), .tx_last_o(tx_last_o), .done_oe_o(done_oe_o));

  // {mode, rx_en, tx_en, rx_avail, tx_full, sw_req, sw_txsel, sw_txgpo, sw_rts, exp_req_n, exp_txreq_n}
  localparam int NVEC = 14;
  localparam logic [11:0] VEC [NVEC] = '{
    12'b01_1010_0000_0_1,
    12'b01_1000_0000_1_1,
    12'b01_0100_0000_0_1,
    12'b01_0101_0000_1_1,
    12'b10_1111_0000_0_1,
    12'b10_1100_0000_1_0,
    12'b10_0110_0000_1_0,
    12'b00_1110_1000_0_1,
    12'b00_0000_0101_1_0,
    12'b00_0000_0010_1_0,
    12'b00_0000_0110_1_1,
    12'b11_1010_1000_0_1,
    12'b01_0101_0101_1_0,
    12'b10_0000_1111_1_1
  };

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic run_ack(input bit a, input bit t,
                         output int nrd, output int nwr, output int ndone,
                         output int nlast, output int frd, output int fwr);
    nrd = 0; nwr = 0; ndone = 0; nlast = 0; frd = -1; fwr = -1;
    @(negedge clk);
    ack_n_i = ~a;
    txack_n_i = ~t;
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      if (rx_rd_o) begin nrd++; if (frd < 0) frd = i; end
      if (tx_wr_o) begin nwr++; if (fwr < 0) fwr = i; end
      if (done_oe_o) ndone++;
      if (tx_last_o) nlast++;
    end
    ack_n_i = 1'b1;
    txack_n_i = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic setup(input logic [1:0] m, input bit re, input bit te,
                       input bit ra, input bit tf);
    mode_i = m; rx_en_i = re; tx_en_i = te; rx_avail_i = ra; tx_full_i = tf;
    rx_last_i = 0; tx_tc_i = 0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int nrd, nwr, nd, nl, frd, fwr;
    repeat (3) @(negedge clk);
    // R11 during reset
    chk(!rx_rd_o && !tx_wr_o && !done_oe_o && !tx_last_o, "R11 strobes in reset",
        {rx_rd_o, tx_wr_o, done_oe_o, tx_last_o}, 0);
    chk(ack_lvl_o && txack_lvl_o, "R11 ack levels in reset", {ack_lvl_o, txack_lvl_o}, 3);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(!rx_rd_o && !tx_wr_o && !done_oe_o && !tx_last_o, "R11 strobes after reset",
        {rx_rd_o, tx_wr_o, done_oe_o, tx_last_o}, 0);

    // R1 R2 R3 R4 request pin table
    for (int v = 0; v < NVEC; v++) begin
      {mode_i, rx_en_i, tx_en_i, rx_avail_i, tx_full_i,
       sw_req_i, sw_txsel_i, sw_txgpo_i, sw_rts_i} = VEC[v][11:2];
      #1;
      chk(req_n_o == VEC[v][1], $sformatf("R2/R3/R4 req_n vec %0d", v), req_n_o, VEC[v][1]);
      chk(txreq_n_o == VEC[v][0], $sformatf("R3/R4 txreq_n vec %0d", v), txreq_n_o, VEC[v][0]);
    end
    {sw_req_i, sw_txsel_i, sw_txgpo_i, sw_rts_i} = 4'b0;

    // R8 level follows pin with two-edge delay
    setup(2'b00, 0, 0, 0, 0);
    @(negedge clk);
    ack_n_i = 0; txack_n_i = 0;
    @(negedge clk);
    chk(ack_lvl_o == 1'b1, "R8 ack level one edge", ack_lvl_o, 1);
    @(negedge clk);
    chk(ack_lvl_o == 1'b0, "R8 ack level two edges", ack_lvl_o, 0);
    chk(txack_lvl_o == 1'b0, "R8 txack level two edges", txack_lvl_o, 0);
    ack_n_i = 1; txack_n_i = 1;
    repeat (4) @(negedge clk);

    // R5 R7 half-duplex receive, held low gives one strobe at index 1
    setup(2'b01, 1, 0, 1, 0);
    run_ack(1, 0, nrd, nwr, nd, nl, frd, fwr);
    chk(nrd == 1, "R7 one read per ack", nrd, 1);
    chk(frd == 1, "R7 read strobe cycle", frd, 1);
    chk(nwr == 0, "R5 no load on rx", nwr, 0);
    chk(nd == 0, "R9 no done on ordinary read", nd, 0);

    // R9 last read drives DONE
    setup(2'b01, 1, 0, 1, 0);
    rx_last_i = 1;
    run_ack(1, 0, nrd, nwr, nd, nl, frd, fwr);
    chk(nd == 1, "R9 done on last read", nd, 1);

    // R5 R9 half-duplex transmit with terminal count
    setup(2'b01, 0, 1, 0, 0);
    tx_tc_i = 1;
    run_ack(1, 0, nrd, nwr, nd, nl, frd, fwr);
    chk(nwr == 1 && nrd == 0, "R5 tx load via shared ack", nwr, 1);
    chk(nd == 1, "R9 done at terminal count", nd, 1);

    // R5 both enabled: receive wins
    setup(2'b01, 1, 1, 1, 0);
    run_ack(1, 0, nrd, nwr, nd, nl, frd, fwr);
    chk(nrd == 1 && nwr == 0, "R5 receive priority", nwr, 0);

    // R6 txack ignored in half-duplex
    setup(2'b01, 0, 1, 0, 0);
    run_ack(0, 1, nrd, nwr, nd, nl, frd, fwr);
    chk(nwr == 0 && nrd == 0, "R6 txack ignored half", nwr, 0);

    // R6 full-duplex both acks together
    setup(2'b10, 1, 1, 1, 0);
    run_ack(1, 1, nrd, nwr, nd, nl, frd, fwr);
    chk(nrd == 1 && nwr == 1, "R6 full read and load", nrd + nwr, 2);
    chk(frd == 1 && fwr == 1, "R6 same strobe cycle", fwr, 1);

    // R7 transmit FIFO full blocks load
    setup(2'b10, 0, 1, 0, 1);
    run_ack(0, 1, nrd, nwr, nd, nl, frd, fwr);
    chk(nwr == 0, "R7 no load when full", nwr, 0);

    // R7 R1 non-DMA modes give no strobes
    setup(2'b00, 1, 1, 1, 0);
    run_ack(1, 1, nrd, nwr, nd, nl, frd, fwr);
    chk(nrd == 0 && nwr == 0, "R7 non-DMA quiet", nrd + nwr, 0);
    setup(2'b11, 1, 1, 1, 0);
    run_ack(1, 1, nrd, nwr, nd, nl, frd, fwr);
    chk(nrd == 0 && nwr == 0, "R1 mode 11 quiet", nrd + nwr, 0);

    // R10 DONE input marks last load
    setup(2'b10, 0, 1, 0, 0);
    done_n_i = 0;
    repeat (3) @(negedge clk);
    run_ack(0, 1, nrd, nwr, nd, nl, frd, fwr);
    chk(nl == 1, "R10 last load flagged", nl, 1);
    done_n_i = 1;
    repeat (3) @(negedge clk);
    run_ack(0, 1, nrd, nwr, nd, nl, frd, fwr);
    chk(nl == 0 && nwr == 1, "R10 ordinary load unflagged", nl, 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule